// File: doc/BRIEF.md
# Wake-Pin Interrupt Controller

This block watches a small set of external wake pins and a few peripheral interrupt lines. The peripheral lines are a real-time clock, an infrared receiver and a watchdog. Each wake pin passes through a synchronizer and then a per-pin trigger detector. The detector can be set to level low, level high, falling edge, rising edge, either edge or no trigger. A detected event is latched into a status register. Software masks the status with an enable register and acknowledges it by writing ones to a clear register.

One shared routing register does two jobs. For each source it holds a bit that lets the source reach its interrupt output, and a separate bit that lets the source raise the wake request. The wake request ignores the enable register, so a source set to wake can request power-up even while its interrupt is masked. Software reaches everything through a flat 32-bit register port with a combinational read path.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset, status, enable and routing read 0, and each pin configuration register (at 0x330 + 8*n) reads mode 4 in bits [3:1]. Status is at 0x310, enable at 0x314, clear at 0x318 and routing at 0x31C. Routing bits that are not implemented read 0.
- R2: A pin's status bit (bit n of 0x310) is set when its configured mode matches. The mode codes are 0 for low level, 1 for high level, 2 for a falling edge, 3 for a rising edge and 6 for either edge. Code 4 never triggers.
- R3: Configuration bit 0 reads the pin level after a two-flop synchronizer. Writes to bit 0 are ignored.
- R4: Writing 1 to configuration bit 4 clears that pin's status bit and its edge history in the same write. Bit 4 always reads 0.
- R5: Writing 1 to bit n of the clear register clears status bit n. A 0 bit leaves that status bit unchanged.
- R6: `pin_irq_o` is high exactly when some n has status[n], enable[n] and routing bit 8+n all set.
- R7: `periph_irq_o[k]` equals `periph_i[k]` AND routing bit k, where k = 0 is the clock, 1 is infrared and 2 is the watchdog.
- R8: `wake_o` is the OR of (status[n] AND routing bit 24+n) and (`periph_i[k]` AND routing bit 16+k), regardless of the enable register.
- R9: In a level mode the status bit is set again on every cycle the level holds, even on the cycle of a clear.
- R10: Mode codes 5 and 7 never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pin_i | input | 4 | Asynchronous wake pins |
| periph_i | input | 3 | Peripheral interrupt inputs: clock, infrared, watchdog |
| pin_irq_o | output | 1 | Combined wake-pin interrupt |
| periph_irq_o | output | 3 | Routed peripheral interrupts |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach is a clear that lands on the same cycle as a detected event. In a level mode this must leave the status bit set. The bench holds a pin at its active level for several cycles and then writes the clear. It reads back a set bit, releases the pin and shows that a second clear now holds.

The edge modes also need care. Each table entry first parks the pin at its start value with the mode set to no trigger. It then writes the new mode together with the history-reset bit, so that no stale edge can leak into the result.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;
  localparam logic [2:0] MODE_LVL_LO = 3'd0;
  localparam logic [2:0] MODE_LVL_HI = 3'd1;
  localparam logic [2:0] MODE_FALL   = 3'd2;
  localparam logic [2:0] MODE_RISE   = 3'd3;
  localparam logic [2:0] MODE_OFF    = 3'd4;
  localparam logic [2:0] MODE_ANY    = 3'd6;

  localparam int OFS_STATUS  = 'h310;
  localparam int OFS_ENABLE  = 'h314;
  localparam int OFS_CLEAR   = 'h318;
  localparam int OFS_ROUTE   = 'h31C;
  localparam int OFS_CFG     = 'h330;
  localparam int CFG_STRIDE  = 8;

  localparam int RT_PER_EXT  = 0;
  localparam int RT_PIN_EXT  = 8;
  localparam int RT_PER_WAKE = 16;
  localparam int RT_PIN_WAKE = 24;

  localparam int CFG_LVL_BIT = 0;
  localparam int CFG_MODE_LO = 1;
  localparam int CFG_RST_BIT = 4;
endpackage

// File: rtl/wake_pin_det.sv
module wake_pin_det
  import wake_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic       hist_clr_i,
  input  logic [2:0] mode_i,
  output logic       level_o,
  output logic       event_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];

  always_comb begin
    unique case (mode_i)
      MODE_LVL_LO: hit = ~level_o;
      MODE_LVL_HI: hit = level_o;
      MODE_FALL:   hit = prev_q & ~level_o;
      MODE_RISE:   hit = ~prev_q & level_o;
      MODE_ANY:    hit = prev_q ^ level_o;
      default:     hit = 1'b0;
    endcase
  end

  // history reset: drop the edge seen this cycle
  assign event_o = hit & ~hist_clr_i;

  assert_rise_seen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RISE && $rose(level_o) && !hist_clr_i) |-> event_o);
  assert_fall_seen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FALL && $fell(level_o) && !hist_clr_i) |-> event_o);
  assert_unused_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd5 || mode_i == 3'd7 || mode_i == MODE_OFF) |-> !event_o);
endmodule

// File: rtl/wake_route.sv
module wake_route #(
  parameter int NUM_PINS   = 4,
  parameter int NUM_PERIPH = 3
) (
  input  logic [NUM_PINS-1:0]   status_i,
  input  logic [NUM_PINS-1:0]   enable_i,
  input  logic [NUM_PINS-1:0]   pin_ext_i,
  input  logic [NUM_PINS-1:0]   pin_wake_i,
  input  logic [NUM_PERIPH-1:0] per_ext_i,
  input  logic [NUM_PERIPH-1:0] per_wake_i,
  input  logic [NUM_PERIPH-1:0] periph_i,
  output logic                  pin_irq_o,
  output logic [NUM_PERIPH-1:0] periph_irq_o,
  output logic                  wake_o
);
  assign pin_irq_o    = |(status_i & enable_i & pin_ext_i);
  assign periph_irq_o = periph_i & per_ext_i;
  // wake path bypasses the enable mask
  assign wake_o       = |(status_i & pin_wake_i) | |(periph_i & per_wake_i);
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int NUM_PERIPH  = 3,
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_PERIPH-1:0] periph_i,
  output logic                  pin_irq_o,
  output logic [NUM_PERIPH-1:0] periph_irq_o,
  output logic                  wake_o
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(OFS_ROUTE);

  logic [NUM_PINS-1:0]   status_q, enable_q, pin_ext_q, pin_wake_q;
  logic [NUM_PERIPH-1:0] per_ext_q, per_wake_q;
  logic [2:0]            mode_q [NUM_PINS];

  logic [NUM_PINS-1:0]   cfg_hit, pin_rst, clr_hit, pin_evt, pin_lvl;
  logic [DATA_W-1:0]     cfg_word [NUM_PINS];

  logic wr_enable, wr_route, wr_clear;
  assign wr_enable = reg_we_i && reg_addr_i == A_ENABLE;
  assign wr_route  = reg_we_i && reg_addr_i == A_ROUTE;
  assign wr_clear  = reg_we_i && reg_addr_i == A_CLEAR;

  logic wdata_unused;
  assign wdata_unused = ^reg_wdata_i;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign cfg_hit[n] = reg_addr_i == ADDR_W'(OFS_CFG + CFG_STRIDE * n);
    assign pin_rst[n] = reg_we_i && cfg_hit[n] && reg_wdata_i[CFG_RST_BIT];
    assign clr_hit[n] = wr_clear && reg_wdata_i[n];

    wake_pin_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pin_i[n]),
      .hist_clr_i(pin_rst[n]),
      .mode_i    (mode_q[n]),
      .level_o   (pin_lvl[n]),
      .event_o   (pin_evt[n])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q[n]   <= MODE_OFF;
        status_q[n] <= 1'b0;
      end else begin
        if (reg_we_i && cfg_hit[n]) mode_q[n] <= reg_wdata_i[CFG_MODE_LO +: 3];
        // a new event wins over a clear in the same cycle
        if (pin_rst[n]) status_q[n] <= 1'b0;
        else            status_q[n] <= (status_q[n] & ~clr_hit[n]) | pin_evt[n];
      end
    end

    always_comb begin
      cfg_word[n] = '0;
      cfg_word[n][CFG_LVL_BIT] = pin_lvl[n];
      cfg_word[n][CFG_MODE_LO +: 3] = mode_q[n];
    end

    assert_clear_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_hit[n] && !pin_evt[n]) |=> !status_q[n]);
    assert_event_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_evt[n] |=> status_q[n]);
    assert_pin_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_rst[n] |=> !status_q[n]);
    assert_status_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!pin_evt[n] && !clr_hit[n] && !pin_rst[n]) |=> $stable(status_q[n]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q   <= '0;
      pin_ext_q  <= '0;
      pin_wake_q <= '0;
      per_ext_q  <= '0;
      per_wake_q <= '0;
    end else begin
      if (wr_enable) enable_q <= reg_wdata_i[NUM_PINS-1:0];
      if (wr_route) begin
        per_ext_q  <= reg_wdata_i[RT_PER_EXT  +: NUM_PERIPH];
        pin_ext_q  <= reg_wdata_i[RT_PIN_EXT  +: NUM_PINS];
        per_wake_q <= reg_wdata_i[RT_PER_WAKE +: NUM_PERIPH];
        pin_wake_q <= reg_wdata_i[RT_PIN_WAKE +: NUM_PINS];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_STATUS) reg_rdata_o[NUM_PINS-1:0] = status_q;
    if (reg_addr_i == A_ENABLE) reg_rdata_o[NUM_PINS-1:0] = enable_q;
    if (reg_addr_i == A_ROUTE) begin
      reg_rdata_o[RT_PER_EXT  +: NUM_PERIPH] = per_ext_q;
      reg_rdata_o[RT_PIN_EXT  +: NUM_PINS]   = pin_ext_q;
      reg_rdata_o[RT_PER_WAKE +: NUM_PERIPH] = per_wake_q;
      reg_rdata_o[RT_PIN_WAKE +: NUM_PINS]   = pin_wake_q;
    end
    for (int n = 0; n < NUM_PINS; n++)
      if (cfg_hit[n]) reg_rdata_o = cfg_word[n];
  end

  wake_route #(.NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH)) u_route (
    .status_i    (status_q),
    .enable_i    (enable_q),
    .pin_ext_i   (pin_ext_q),
    .pin_wake_i  (pin_wake_q),
    .per_ext_i   (per_ext_q),
    .per_wake_i  (per_wake_q),
    .periph_i    (periph_i),
    .pin_irq_o   (pin_irq_o),
    .periph_irq_o(periph_irq_o),
    .wake_o      (wake_o)
  );

  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_irq_o |-> |(status_q & enable_q));
  assert_periph_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_ext_q == '0) |-> (periph_irq_o == '0));
  assert_wake_needs_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_wake_q == '0 && per_wake_q == '0) |-> !wake_o);
endmodule

// File: tb/wake_irq_ctrl_test.sv
module wake_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pins = '0;
  logic [2:0]  periph = '0;
  logic        pin_irq, wake;
  logic [2:0]  periph_irq;

  int n_chk = 0;
  int n_bad = 0;

  wake_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_i(pins), .periph_i(periph),
    .pin_irq_o(pin_irq), .periph_irq_o(periph_irq), .wake_o(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {pin[7:6], mode[5:3], start[2], end[1], expect[0]}
  localparam logic [7:0] VEC [12] = '{
    {2'd0, 3'd3, 1'b0, 1'b1, 1'b1},
    {2'd1, 3'd3, 1'b1, 1'b0, 1'b0},
    {2'd2, 3'd2, 1'b1, 1'b0, 1'b1},
    {2'd3, 3'd2, 1'b0, 1'b1, 1'b0},
    {2'd0, 3'd6, 1'b0, 1'b1, 1'b1},
    {2'd1, 3'd6, 1'b1, 1'b0, 1'b1},
    {2'd2, 3'd1, 1'b0, 1'b1, 1'b1},
    {2'd3, 3'd0, 1'b1, 1'b0, 1'b1},
    {2'd0, 3'd4, 1'b0, 1'b1, 1'b0},
    {2'd1, 3'd5, 1'b0, 1'b1, 1'b0},
    {2'd2, 3'd7, 1'b1, 1'b0, 1'b0},
    {2'd3, 3'd6, 1'b1, 1'b1, 1'b0}
  };

  localparam logic [11:0] A_ST = 12'h310, A_EN = 12'h314, A_CL = 12'h318, A_RT = 12'h31C;

  function automatic logic [11:0] cfg_a(int p);
    return 12'(12'h330 + 8 * p);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    rd(A_ST, v); chk("R1 status", v, 0);
    rd(A_EN, v); chk("R1 enable", v, 0);
    rd(A_RT, v); chk("R1 route", v, 0);
    for (int p = 0; p < 4; p++) begin
      rd(cfg_a(p), v); chk("R1 cfg mode", v, 32'h8);
    end
    chk("R1 outputs", {pin_irq, wake, periph_irq}, 0);

    // R2/R10 mode table
    for (int i = 0; i < 12; i++) begin
      int p;
      p = int'(VEC[i][7:6]);
      wr(cfg_a(p), 32'h8);
      pins[p] = VEC[i][2];
      cyc(4);
      wr(cfg_a(p), 32'h10 | (32'(VEC[i][5:3]) << 1));
      wr(A_CL, 32'(1) << p);
      pins[p] = VEC[i][1];
      cyc(5);
      rd(A_ST, v);
      chk($sformatf("R2 R10 mode table entry %0d", i), 32'(v[p]), 32'(VEC[i][0]));
      wr(cfg_a(p), 32'h8);
    end
    pins = '0;
    wr(A_CL, 32'hF);
    cyc(4);

    // R3 synchronized level, bit 0 not writable
    pins[1] = 1'b1;
    cyc(3);
    rd(cfg_a(1), v); chk("R3 level readback", v, 32'h9);
    wr(cfg_a(1), 32'h8);
    rd(cfg_a(1), v); chk("R3 write bit0 ignored", v, 32'h9);

    // R4 per-pin reset
    wr(cfg_a(2), 32'h16);
    wr(A_CL, 32'hF);
    pins[2] = 1'b1;
    cyc(5);
    rd(A_ST, v); chk("R4 rise latched", 32'(v[2]), 1);
    wr(cfg_a(2), 32'h16);
    rd(A_ST, v); chk("R4 reset clears status", 32'(v[2]), 0);
    rd(cfg_a(2), v); chk("R4 reset bit reads 0", v, 32'h7);

    // R5 clear semantics
    pins[2] = 1'b0; cyc(5);
    pins[2] = 1'b1; cyc(5);
    rd(A_ST, v); chk("R5 setup", 32'(v[2]), 1);
    wr(A_CL, 32'hB);
    rd(A_ST, v); chk("R5 zero bit no effect", 32'(v[2]), 1);
    wr(A_CL, 32'h4);
    rd(A_ST, v); chk("R5 one bit clears", 32'(v[2]), 0);

    // R9 level re-set after clear
    wr(cfg_a(3), 32'h12);
    pins[3] = 1'b1; cyc(5);
    wr(A_CL, 32'h8);
    rd(A_ST, v); chk("R9 level survives clear", 32'(v[3]), 1);
    pins[3] = 1'b0; cyc(5);
    wr(A_CL, 32'h8);
    rd(A_ST, v); chk("R9 clear after release", 32'(v[3]), 0);

    // R6 interrupt gating (pin2 rising mode)
    pins[2] = 1'b0; cyc(5);
    pins[2] = 1'b1; cyc(5);
    wr(A_EN, 32'h0); wr(A_RT, 32'h400);
    #1 chk("R6 enable off", 32'(pin_irq), 0);
    wr(A_EN, 32'h4); wr(A_RT, 32'h0);
    #1 chk("R6 route off", 32'(pin_irq), 0);
    wr(A_RT, 32'h400);
    #1 chk("R6 both on", 32'(pin_irq), 1);
    wr(A_RT, 32'h800);
    #1 chk("R6 other pin routed", 32'(pin_irq), 0);

    // R8 wake independent of enable
    wr(A_EN, 32'h0);
    wr(A_RT, 32'h0400_0000);
    #1 chk("R8 pin wake", 32'(wake), 1);
    wr(A_CL, 32'h4);
    #1 chk("R8 pin wake cleared", 32'(wake), 0);
    wr(A_RT, 32'h0002_0000);
    periph = 3'b010; #1 chk("R8 periph wake", 32'(wake), 1);
    periph = 3'b001; #1 chk("R8 periph not routed", 32'(wake), 0);

    // R7 peripheral routing
    wr(A_RT, 32'h5);
    periph = 3'b111; #1 chk("R7 routed", 32'(periph_irq), 32'h5);
    periph = 3'b010; #1 chk("R7 unrouted", 32'(periph_irq), 32'h0);
    rd(A_RT, v); chk("R7 route readback", v, 32'h5);
    wr(A_RT, 32'hFFFF_FFFF);
    rd(A_RT, v); chk("R1 route unused bits", v, 32'h0F07_0F07);

    summary();
    $finish;
  end
endmodule